// File: doc/BRIEF.md
# Dual-Lane Lockstep Aligner with Zero Fill

This block takes two independent packet streams and merges them into one pair of lanes that advance together. Each lane is 64 bits of data with an 8-bit control byte: a header word is marked by control `8'hFF`, body words by `8'h00`, and the final word of a packet by a control byte with exactly one bit set. When headers show up on both inputs in the same cycle, the two packets travel side by side, one word from each per output beat. A later arithmetic stage can then combine them word for word.

When a paired packet runs out before its partner, its lane is filled with all-zero words tagged with a fill code until the longer packet finishes. A header that arrives while the other channel is already moving a packet on its own is held off. It is arbitrated again once that packet is done. The output has one shared valid and one shared ready, plus a per-lane activity flag so that a consumer can tell a lone packet from a pair.

Top module: `dual_lane_aligner`

## Requirements
- R1: When both inputs present a header (control `8'hFF`) in the same cycle while the block is idle, both headers leave in the same output beat with both lane activity flags high, and the rest of the two packets follow as pairs.
- R2: A header arriving on one input while the other input's packet is being forwarded alone is held (its ready stays low) until that packet's last word is taken. It is then forwarded as its own packet.
- R3: Two paired packets of equal length produce no fill words.
- R4: When one paired packet ends first, its lane carries all-zero data words, one per beat, until the partner's last word. The number of fill words equals the difference in lengths, and every fill word sits next to a real word on the other lane.
- R5: Fill words carry control `8'hF0`. This code differs from the header code `8'hFF` and from every one-hot last-word code.
- R6: A packet ends at the word whose control byte is nonzero with exactly one bit set. After the longer packet's last word the block is idle and decides the next packets afresh.
- R7: While two packets are paired, a word is taken from a non-filling lane only when both non-filling inputs are valid and the output register has room. While `out_ready` is low, the output beat is held unchanged.
- R8: A non-header word that arrives on an input while the block is idle is consumed and discarded, and produces no output beat.
- R9: Every word of every packet appears on its own lane, in order and unmodified.
- R10: An inactive lane in a beat (activity flag low) carries zero data and zero control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_data | input | 64 | Channel A data word |
| a_ctrl | input | 8 | Channel A control byte |
| a_valid | input | 1 | Channel A word present |
| a_ready | output | 1 | Channel A word taken this cycle when valid |
| b_data | input | 64 | Channel B data word |
| b_ctrl | input | 8 | Channel B control byte |
| b_valid | input | 1 | Channel B word present |
| b_ready | output | 1 | Channel B word taken this cycle when valid |
| out_a_data | output | 64 | Lane A data of the output beat |
| out_a_ctrl | output | 8 | Lane A control of the output beat |
| out_a_act | output | 1 | Lane A carries a word or a fill word |
| out_b_data | output | 64 | Lane B data of the output beat |
| out_b_ctrl | output | 8 | Lane B control of the output beat |
| out_b_act | output | 1 | Lane B carries a word or a fill word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |

## Verification
A wrong arbitration state shows at the ports within one beat of its cause. If the block stays paired too long, fill words appear where a lone packet should have been, or the second lane's ready stalls. If it leaves a pairing early, the longer packet's remaining words come out with the other lane inactive instead of filled. A lost or doubled handshake shows as a missing, repeated or reordered word on a lane's stream. The fill count per pair, compared with the length difference, shows a fill state entered or left one beat off.

// File: rtl/dual_lane_aligner_pkg.sv
package dual_lane_aligner_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAIR,
    ST_SOLO_A,
    ST_SOLO_B,
    ST_FILL_A,   // lane A is filling, lane B still forwarding
    ST_FILL_B    // lane B is filling, lane A still forwarding
  } arb_state_t;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_IN,
    SRC_FILL
  } lane_src_t;

endpackage

// File: rtl/dla_word_class.sv
module dla_word_class #(
  parameter int          CTRL_W   = 8,
  parameter logic [7:0]  HDR_CODE = 8'hFF
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic              is_hdr,
  output logic              is_last
);

  localparam logic [CTRL_W-1:0] HDR = CTRL_W'(HDR_CODE);

  always_comb begin
    is_hdr  = (ctrl == HDR);
    is_last = (ctrl != '0) && ((ctrl & (ctrl - 1'b1)) == '0);
  end

endmodule

// File: rtl/dla_arb_fsm.sv
module dla_arb_fsm
  import dual_lane_aligner_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      a_valid,
  input  logic      a_hdr,
  input  logic      a_last,
  input  logic      b_valid,
  input  logic      b_hdr,
  input  logic      b_last,
  input  logic      room,
  output logic      a_ready,
  output logic      b_ready,
  output lane_src_t a_src,
  output lane_src_t b_src,
  output logic      fire
);

  arb_state_t state, state_nx;
  logic a_new, b_new;

  always_comb begin
    a_new    = a_valid && a_hdr;
    b_new    = b_valid && b_hdr;
    state_nx = state;
    a_ready  = 1'b0;
    b_ready  = 1'b0;
    a_src    = SRC_NONE;
    b_src    = SRC_NONE;
    fire     = 1'b0;
    case (state)
      ST_IDLE: begin
        // headers wait for room, stray words are dropped at once
        a_ready = a_hdr ? room : 1'b1;
        b_ready = b_hdr ? room : 1'b1;
        a_src   = a_new ? SRC_IN : SRC_NONE;
        b_src   = b_new ? SRC_IN : SRC_NONE;
        fire    = room && (a_new || b_new);
        if (room) begin
          if (a_new && b_new) state_nx = ST_PAIR;
          else if (a_new)     state_nx = ST_SOLO_A;
          else if (b_new)     state_nx = ST_SOLO_B;
        end
      end
      ST_PAIR: begin
        a_ready = b_valid && room;
        b_ready = a_valid && room;
        a_src   = SRC_IN;
        b_src   = SRC_IN;
        fire    = a_valid && b_valid && room;
        if (fire) begin
          if (a_last && b_last) state_nx = ST_IDLE;
          else if (a_last)      state_nx = ST_FILL_A;
          else if (b_last)      state_nx = ST_FILL_B;
        end
      end
      ST_FILL_A: begin
        b_ready = room;
        a_src   = SRC_FILL;
        b_src   = SRC_IN;
        fire    = b_valid && room;
        if (fire && b_last) state_nx = ST_IDLE;
      end
      ST_FILL_B: begin
        a_ready = room;
        a_src   = SRC_IN;
        b_src   = SRC_FILL;
        fire    = a_valid && room;
        if (fire && a_last) state_nx = ST_IDLE;
      end
      ST_SOLO_A: begin
        a_ready = room;
        a_src   = SRC_IN;
        fire    = a_valid && room;
        if (fire && a_last) state_nx = ST_IDLE;
      end
      ST_SOLO_B: begin
        b_ready = room;
        b_src   = SRC_IN;
        fire    = b_valid && room;
        if (fire && b_last) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  assert_pair_start_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && a_new && b_new && room) |=> (state == ST_PAIR));

  assert_stall_other_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SOLO_A && b_valid) |-> !b_ready);

  assert_to_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAIR && fire && a_last && !b_last) |=> (state == ST_FILL_A));

  assert_end_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAIR && fire && a_last && b_last) |=> (state == ST_IDLE));

endmodule

// File: rtl/dla_lane_stage.sv
module dla_lane_stage
  import dual_lane_aligner_pkg::*;
#(
  parameter int         DATA_W    = 64,
  parameter int         CTRL_W    = 8,
  parameter logic [7:0] FILL_CODE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  lane_src_t         src,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  output logic [DATA_W-1:0] q_data,
  output logic [CTRL_W-1:0] q_ctrl,
  output logic              q_act
);

  localparam logic [CTRL_W-1:0] FILL = CTRL_W'(FILL_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_data <= '0;
      q_ctrl <= '0;
      q_act  <= 1'b0;
    end else if (ld) begin
      case (src)
        SRC_IN: begin
          q_data <= in_data;
          q_ctrl <= in_ctrl;
          q_act  <= 1'b1;
        end
        SRC_FILL: begin
          q_data <= '0;
          q_ctrl <= FILL;
          q_act  <= 1'b1;
        end
        default: begin
          q_data <= '0;
          q_ctrl <= '0;
          q_act  <= 1'b0;
        end
      endcase
    end
  end

  assert_idle_lane_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !q_act |-> (q_data == '0 && q_ctrl == '0));

endmodule

// File: rtl/dual_lane_aligner.sv
module dual_lane_aligner
  import dual_lane_aligner_pkg::*;
#(
  parameter int         DATA_W    = 64,
  parameter int         CTRL_W    = 8,
  parameter logic [7:0] HDR_CODE  = 8'hFF,
  parameter logic [7:0] FILL_CODE = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a_data,
  input  logic [CTRL_W-1:0] a_ctrl,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic [DATA_W-1:0] b_data,
  input  logic [CTRL_W-1:0] b_ctrl,
  input  logic              b_valid,
  output logic              b_ready,
  output logic [DATA_W-1:0] out_a_data,
  output logic [CTRL_W-1:0] out_a_ctrl,
  output logic              out_a_act,
  output logic [DATA_W-1:0] out_b_data,
  output logic [CTRL_W-1:0] out_b_ctrl,
  output logic              out_b_act,
  output logic              out_valid,
  input  logic              out_ready
);

  localparam int                NLANE = 2;
  localparam logic [CTRL_W-1:0] FILL  = CTRL_W'(FILL_CODE);

  logic [DATA_W-1:0] in_d   [NLANE];
  logic [CTRL_W-1:0] in_c   [NLANE];
  logic [DATA_W-1:0] q_d    [NLANE];
  logic [CTRL_W-1:0] q_c    [NLANE];
  logic              q_act  [NLANE];
  logic              hdr    [NLANE];
  logic              last   [NLANE];
  lane_src_t         src    [NLANE];

  logic room, fire, valid_q;

  assign in_d[0] = a_data;
  assign in_c[0] = a_ctrl;
  assign in_d[1] = b_data;
  assign in_c[1] = b_ctrl;

  assign room = !valid_q || out_ready;

  generate
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
      dla_word_class #(
        .CTRL_W  (CTRL_W),
        .HDR_CODE(HDR_CODE)
      ) i_class (
        .ctrl   (in_c[i]),
        .is_hdr (hdr[i]),
        .is_last(last[i])
      );

      dla_lane_stage #(
        .DATA_W   (DATA_W),
        .CTRL_W   (CTRL_W),
        .FILL_CODE(FILL_CODE)
      ) i_stage (
        .clk    (clk),
        .rst    (rst),
        .ld     (fire),
        .src    (src[i]),
        .in_data(in_d[i]),
        .in_ctrl(in_c[i]),
        .q_data (q_d[i]),
        .q_ctrl (q_c[i]),
        .q_act  (q_act[i])
      );
    end
  endgenerate

  dla_arb_fsm i_fsm (
    .clk    (clk),
    .rst    (rst),
    .a_valid(a_valid),
    .a_hdr  (hdr[0]),
    .a_last (last[0]),
    .b_valid(b_valid),
    .b_hdr  (hdr[1]),
    .b_last (last[1]),
    .room   (room),
    .a_ready(a_ready),
    .b_ready(b_ready),
    .a_src  (src[0]),
    .b_src  (src[1]),
    .fire   (fire)
  );

  always_ff @(posedge clk) begin
    if (rst)       valid_q <= 1'b0;
    else if (room) valid_q <= fire;
  end

  assign out_valid  = valid_q;
  assign out_a_data = q_d[0];
  assign out_a_ctrl = q_c[0];
  assign out_a_act  = q_act[0];
  assign out_b_data = q_d[1];
  assign out_b_ctrl = q_c[1];
  assign out_b_act  = q_act[1];

  assert_hold_beat_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_a_data) && $stable(out_b_data)
                                   && $stable(out_a_ctrl) && $stable(out_b_ctrl)));

  assert_fill_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_a_ctrl == FILL) |-> (out_a_data == '0 && out_b_act && out_b_ctrl != FILL));

  assert_fill_zero_b_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_b_ctrl == FILL) |-> (out_b_data == '0 && out_a_act && out_a_ctrl != FILL));

  assert_beat_has_lane_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_a_act || out_b_act));

endmodule

// File: tb/test_dual_lane_aligner.sv
module test_dual_lane_aligner;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] HDR  = 8'hFF;
  localparam logic [7:0] FILL = 8'hF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a_data = '0, b_data = '0;
  logic [7:0]  a_ctrl = '0, b_ctrl = '0;
  logic        a_valid = 1'b0, b_valid = 1'b0;
  logic        a_ready, b_ready;
  logic [63:0] out_a_data, out_b_data;
  logic [7:0]  out_a_ctrl, out_b_ctrl;
  logic        out_a_act, out_b_act, out_valid;
  logic        out_ready = 1'b1;

  int checks = 0, fails = 0;
  int beats = 0, fills_a = 0, fills_b = 0, solo_a = 0, solo_b = 0, both = 0;
  int stall_a = 0, stall_b = 0;
  int gap_pct = 0, hold_pct = 0;
  int seq = 0;
  logic [71:0] tx_a[$], tx_b[$], exp_a[$], exp_b[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_lane_aligner i_dual_lane_aligner (
    .clk(clk), .rst(rst),
    .a_data(a_data), .a_ctrl(a_ctrl), .a_valid(a_valid), .a_ready(a_ready),
    .b_data(b_data), .b_ctrl(b_ctrl), .b_valid(b_valid), .b_ready(b_ready),
    .out_a_data(out_a_data), .out_a_ctrl(out_a_ctrl), .out_a_act(out_a_act),
    .out_b_data(out_b_data), .out_b_ctrl(out_b_ctrl), .out_b_act(out_b_act),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] last_code();
    return 8'h01 << ($urandom % 8);
  endfunction

  task automatic push_pkt(input int ch, input int len, input bit keep);
    logic [71:0] w;
    seq++;
    for (int i = 0; i < len; i++) begin
      if (i == 0)            w = {HDR, 16'hC0DE, 8'(ch), 8'(seq), 32'($urandom)};
      else if (i == len - 1) w = {last_code(), 32'($urandom), 32'($urandom)};
      else                   w = {8'h00, 32'($urandom), 32'($urandom)};
      if (ch == 0) begin tx_a.push_back(w); if (keep) exp_a.push_back(w); end
      else         begin tx_b.push_back(w); if (keep) exp_b.push_back(w); end
    end
  endtask

  task automatic push_stray_a();
    tx_a.push_back({8'h00, 64'hDEAD_0000_BEEF_0001});
  endtask

  // channel drivers
  initial forever begin
    @(negedge clk);
    if (!rst && tx_a.size() > 0 && int'($urandom % 100) >= gap_pct) begin
      a_valid = 1'b1; {a_ctrl, a_data} = tx_a[0];
    end else a_valid = 1'b0;
    #1;
    if (a_valid && !a_ready) stall_a++;
    if (a_valid && a_ready) void'(tx_a.pop_front());
  end

  initial forever begin
    @(negedge clk);
    if (!rst && tx_b.size() > 0 && int'($urandom % 100) >= gap_pct) begin
      b_valid = 1'b1; {b_ctrl, b_data} = tx_b[0];
    end else b_valid = 1'b0;
    #1;
    if (b_valid && !b_ready) stall_b++;
    if (b_valid && b_ready) void'(tx_b.pop_front());
  end

  initial forever begin
    @(negedge clk);
    out_ready = (int'($urandom % 100) >= hold_pct);
  end

  task automatic lane_mon(input int ln, input logic act, input logic [7:0] c, input logic [63:0] d,
                          input logic oact, input logic [7:0] oc);
    logic [71:0] e;
    if (!act) begin
      chk(c == 8'h00 && d == '0, "R10 inactive lane zero", {c, d}, 72'h0);
    end else if (c == FILL) begin
      if (ln == 0) fills_a++; else fills_b++;
      chk(d == '0 && oact && oc != FILL, "R4 fill word zero beside real word", {oc, d}, 72'h0);
    end else begin
      if (ln == 0) begin
        e = (exp_a.size() > 0) ? exp_a.pop_front() : 72'hX;
        chk({c, d} === e, "R9 lane A word", {c, d}, e);
      end else begin
        e = (exp_b.size() > 0) ? exp_b.pop_front() : 72'hX;
        chk({c, d} === e, "R9 lane B word", {c, d}, e);
      end
    end
  endtask

  initial forever begin
    @(negedge clk);
    #2;
    if (!rst && out_valid && out_ready) begin
      beats++;
      if (out_a_act && out_b_act) both++;
      else if (out_a_act) solo_a++;
      else if (out_b_act) solo_b++;
      lane_mon(0, out_a_act, out_a_ctrl, out_a_data, out_b_act, out_b_ctrl);
      lane_mon(1, out_b_act, out_b_ctrl, out_b_data, out_a_act, out_a_ctrl);
    end
  end

  task automatic clear_counts();
    beats = 0; fills_a = 0; fills_b = 0; solo_a = 0; solo_b = 0; both = 0;
    stall_a = 0; stall_b = 0;
  endtask

  task automatic drain();
    while (tx_a.size() > 0 || tx_b.size() > 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #3;
    chk(out_valid == 1'b0, "reset out_valid low", 72'(out_valid), 72'h0);
    chk(a_ready && b_ready, "R8 idle inputs ready after reset", 72'({a_ready, b_ready}), 72'h3);

    // R1/R3: equal lengths side by side
    clear_counts(); push_pkt(0, 4, 1); push_pkt(1, 4, 1); drain();
    chk(beats == 4 && both == 4, "R1 paired beats", 72'(beats), 72'd4);
    chk(fills_a == 0 && fills_b == 0, "R3 no fill on equal length", 72'(fills_a + fills_b), 72'd0);

    // R4/R5: A shorter
    clear_counts(); push_pkt(0, 2, 1); push_pkt(1, 5, 1); drain();
    chk(beats == 5, "R4 beats follow longer packet", 72'(beats), 72'd5);
    chk(fills_a == 3, "R5 fill count on lane A", 72'(fills_a), 72'd3);

    // R4: B shorter
    clear_counts(); push_pkt(0, 6, 1); push_pkt(1, 3, 1); drain();
    chk(fills_b == 3 && fills_a == 0, "R4 fill count on lane B", 72'(fills_b), 72'd3);
    chk(both == 6, "R6 pair lasts until longer last word", 72'(both), 72'd6);

    // R2: A starts alone, B header one cycle later is held
    clear_counts();
    @(negedge clk); #3 push_pkt(0, 4, 1);
    @(negedge clk); #3 push_pkt(1, 3, 1);
    drain();
    chk(stall_b == 3, "R2 B held while A alone", 72'(stall_b), 72'd3);
    chk(solo_a == 4 && solo_b == 3 && both == 0, "R2 served separately", 72'({solo_a, solo_b}), 72'h0000000400000003);

    // R2 symmetric
    clear_counts();
    @(negedge clk); #3 push_pkt(1, 5, 1);
    @(negedge clk); #3 push_pkt(0, 2, 1);
    drain();
    chk(stall_a == 4, "R2 A held while B alone", 72'(stall_a), 72'd4);
    chk(solo_b == 5 && solo_a == 2, "R6 rearbitrated after end", 72'({solo_a, solo_b}), 72'h0000000200000005);

    // R8: stray word in idle dropped
    clear_counts();
    @(negedge clk); #3 push_stray_a();
    drain();
    chk(beats == 0, "R8 stray word makes no beat", 72'(beats), 72'd0);
    push_pkt(0, 2, 1); drain();
    chk(beats == 2 && exp_a.size() == 0, "R8 following packet intact", 72'(beats), 72'd2);

    // R7: backpressure on a pair
    clear_counts(); hold_pct = 50;
    push_pkt(0, 3, 1); push_pkt(1, 7, 1); drain();
    repeat (20) @(negedge clk);
    chk(beats == 7 && fills_a == 4, "R7 pair under backpressure", 72'({beats, fills_a}), 72'h0000000700000004);

    // random traffic with gaps and backpressure
    gap_pct = 30; hold_pct = 30;
    for (int k = 0; k < 60; k++) begin
      push_pkt(0, 2 + int'($urandom % 8), 1);
      push_pkt(1, 2 + int'($urandom % 8), 1);
    end
    drain();
    hold_pct = 0;
    repeat (20) @(negedge clk);
    chk(exp_a.size() == 0, "R9 all lane A words delivered", 72'(exp_a.size()), 72'd0);
    chk(exp_b.size() == 0, "R9 all lane B words delivered", 72'(exp_b.size()), 72'd0);
    chk(out_valid == 1'b0, "R7 output empty at end", 72'(out_valid), 72'd0);

    summary();
    $finish;
  end

endmodule